// File: doc/BRIEF.md
# Wormhole Output Channel Allocator

This block hands one router output channel to one packet at a time in a wormhole-switched router. It has one port for local traffic entering the network and a parameterised number of network input channels. Each of these has its own small flit FIFO. When a packet's first flit reaches the front of a FIFO and route computation marks that packet for this output, the input asks for the channel. A fixed-priority arbiter picks one asking input, and a lock register then ties the channel to that input. Every flit of that packet then crosses in order. The lock stays until the packet's last flit has left its FIFO, and only then does the next arbitration round start.

A flit is `DATA_W + 2` bits wide. Its top two bits hold the flit kind: `00` body, `01` head, `10` tail, `11` a one-flit packet. All flit interfaces are valid/ready. An input accepts a flit whenever its FIFO has room, and `in_ready` drops only when that FIFO is full. On the output side, a flit that is offered while `out_ready` is low stays in place until it is taken. While it waits, the lock is kept and nothing is popped, so no flit is lost or repeated.

A packet takes two register stages through the block. In the first, the arbitration result is captured in the lock register. In the second, flits move through the switch mux into the output register.

Top module: `wh_out_alloc`

## Requirements
- R1: After reset, `out_valid` is 0, no input holds the channel, and every `in_ready` is 1 because all FIFOs are empty.
- R2: Each input FIFO holds `FIFO_DEPTH` flits. A flit is accepted on a cycle with `in_valid` and `in_ready` both high. `in_ready` is 0 exactly when that FIFO is full.
- R3: Only a flit whose kind has bit 0 set (head `01` or single `11`) can start arbitration. It must sit at the front of its FIFO with its `route_hit` bit high. A body flit (`00`) or tail flit (`10`) at the front never takes the channel.
- R4: Once an input is granted, the channel stays with it until its closing flit (kind bit 1 set: tail `10` or single `11`) leaves the FIFO. Flits of different packets never interleave on the output.
- R5: Index 0 is the entry port and is served before every network input. Network inputs 1..NUM_NET rank in falling priority as the index rises. When several inputs ask for a free channel in the same cycle, the lowest index wins.
- R6: An input that loses arbitration, or asks while the channel is held, keeps its flits and is granted after the channel is freed.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_flit` and `out_valid` hold their values. No flit is dropped or duplicated under back-pressure.
- R8: The flits of a packet leave in the order they were accepted.
- R9: If a requesting head flit is set up before clock edge N and the channel is free, it appears on the output after edge N+1, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NUM_NET+1 | Per-input flit valid; bit 0 is the entry port |
| in_ready | output | NUM_NET+1 | Per-input FIFO has room |
| in_flit | input | (NUM_NET+1)*(DATA_W+2) | Flat flits; input i at bits i*(DATA_W+2) upward; kind in top 2 bits |
| route_hit | input | NUM_NET+1 | Route result: head flit at front of input i targets this output |
| out_valid | output | 1 | Output flit valid |
| out_ready | input | 1 | Downstream accepts the flit |
| out_flit | output | DATA_W+2 | Output flit, same layout as inputs |

## Verification
The bench preloads every FIFO while the route bits are low, then raises all of them in the same cycle. A design with the wrong priority order, or one that misses the entry-port override, sends the packets in a different order. A packet whose head flit is already out when the entry port starts asking checks the lock. A design that re-arbitrates per flit would slip the entry flit into the middle of that packet. Random output back-pressure catches a design that pops its FIFO or changes the output while stalled, which shows up as lost, repeated or altered flits. A stray body flit at the front of a FIFO must never be granted. The exact first-flit latency is checked so that a merged pipeline is caught.

// File: rtl/wh_alloc_pkg.sv
`timescale 1ns/1ps
package wh_alloc_pkg;
  // Flit kind field, carried in the two top bits of every flit.
  typedef enum logic [1:0] {
    FK_BODY = 2'b00,
    FK_HEAD = 2'b01,
    FK_TAIL = 2'b10,
    FK_SOLO = 2'b11
  } flit_kind_e;

  // Bit 0 of the kind marks a flit that opens a packet.
  function automatic logic opens_pkt(input logic [1:0] kind);
    return kind[0];
  endfunction

  // Bit 1 of the kind marks a flit that closes a packet.
  function automatic logic closes_pkt(input logic [1:0] kind);
    return kind[1];
  endfunction
endpackage

// File: rtl/wh_flit_fifo.sv
`timescale 1ns/1ps
module wh_flit_fifo #(
  parameter int WIDTH = 34,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end
endmodule

// File: rtl/wh_fixed_arb.sv
`timescale 1ns/1ps
module wh_fixed_arb #(
  parameter int N = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] win
);
  // Lowest index wins: scan from the top so the last hit is the smallest.
  always_comb begin
    any = |req;
    win = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) win = IW'(k);
    end
  end
endmodule

// File: rtl/wh_chan_lock.sv
`timescale 1ns/1ps
module wh_chan_lock #(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any_req,
  input  logic [IW-1:0] win,
  input  logic          rel,
  output logic          busy,
  output logic [IW-1:0] owner
);
  // Stage one: arbitration result is captured here; held until release.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      owner <= '0;
    end else if (busy) begin
      if (rel) busy <= 1'b0;
    end else if (any_req) begin
      busy  <= 1'b1;
      owner <= win;
    end
  end
endmodule

// File: rtl/wh_out_alloc.sv
`timescale 1ns/1ps
module wh_out_alloc
  import wh_alloc_pkg::*;
#(
  parameter int NUM_NET    = 4,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 4,
  localparam int NUM_IN = NUM_NET + 1,
  localparam int FLIT_W = DATA_W + 2,
  localparam int IDX_W  = $clog2(NUM_IN)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_IN-1:0]        in_valid,
  output logic [NUM_IN-1:0]        in_ready,
  input  logic [NUM_IN*FLIT_W-1:0] in_flit,
  input  logic [NUM_IN-1:0]        route_hit,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [FLIT_W-1:0]        out_flit
);
  logic [FLIT_W-1:0] fifo_front [NUM_IN];
  logic [NUM_IN-1:0] fifo_empty, fifo_full, fifo_pop, req;
  logic              any_req, lock_busy, lock_rel, xfer, load_out;
  logic [IDX_W-1:0]  win_idx, lock_owner;
  logic [FLIT_W-1:0] sel_front;
  logic              sel_empty;

  for (genvar g = 0; g < NUM_IN; g++) begin : g_in
    wh_flit_fifo #(.WIDTH(FLIT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (in_valid[g]),
      .din   (in_flit[g*FLIT_W +: FLIT_W]),
      .pop   (fifo_pop[g]),
      .dout  (fifo_front[g]),
      .full  (fifo_full[g]),
      .empty (fifo_empty[g])
    );
    assign in_ready[g] = !fifo_full[g];
    assign req[g]      = !fifo_empty[g] && route_hit[g]
                         && opens_pkt(fifo_front[g][FLIT_W-1 -: 2]);
    assign fifo_pop[g] = xfer && (lock_owner == IDX_W'(g));
  end

  wh_fixed_arb #(.N(NUM_IN)) u_arb (
    .req (req),
    .any (any_req),
    .win (win_idx)
  );

  wh_chan_lock #(.IW(IDX_W)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .any_req (any_req),
    .win     (win_idx),
    .rel     (lock_rel),
    .busy    (lock_busy),
    .owner   (lock_owner)
  );

  // Switch mux: front flit of the input that owns the channel.
  always_comb begin
    sel_front = '0;
    sel_empty = 1'b1;
    for (int k = 0; k < NUM_IN; k++) begin
      if (lock_owner == IDX_W'(k)) begin
        sel_front = fifo_front[k];
        sel_empty = fifo_empty[k];
      end
    end
  end

  assign load_out = !out_valid || out_ready;
  assign xfer     = load_out && lock_busy && !sel_empty;
  assign lock_rel = xfer && closes_pkt(sel_front[FLIT_W-1 -: 2]);

  // Stage two: switch traversal into the output register.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_flit  <= '0;
    end else if (load_out) begin
      out_valid <= xfer;
      if (xfer) out_flit <= sel_front;
    end
  end
endmodule

// File: rtl/wh_alloc_chk.sv
`timescale 1ns/1ps
module wh_alloc_chk #(
  parameter int NUM_IN = 5,
  parameter int FLIT_W = 34,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [FLIT_W-1:0] out_flit,
  input logic              lock_busy,
  input logic [IDX_W-1:0]  lock_owner,
  input logic [NUM_IN-1:0] req
);
  logic pkt_open;
  logic out_take;
  assign out_take = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) pkt_open <= 1'b0;
    else if (out_take) pkt_open <= !out_flit[FLIT_W-1];
  end

  // R3: nothing requests a free channel -> it stays free
  assert_no_spurious_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_busy && req == '0) |=> !lock_busy);

  // R4: the owner never changes while the channel is held
  assert_lock_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_busy |=> (!lock_busy || $stable(lock_owner)));

  // R4: an opening flit only leaves when no packet is open
  assert_no_interleave_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flit[FLIT_W-2]) |-> !pkt_open);

  // R4: a continuing flit only leaves inside an open packet
  assert_no_orphan_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_flit[FLIT_W-2]) |-> pkt_open);

  // R5: the entry port wins a free channel
  assert_entry_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_busy && req[0]) |=> (lock_busy && lock_owner == '0));

  // R7: a stalled output flit holds
  assert_hold_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_flit)));
endmodule

bind wh_out_alloc wh_alloc_chk #(.NUM_IN(NUM_IN), .FLIT_W(FLIT_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_flit   (out_flit),
  .lock_busy  (lock_busy),
  .lock_owner (lock_owner),
  .req        (req)
);

// File: tb/wh_out_alloc_test.sv
`timescale 1ns/1ps
module wh_out_alloc_test;
  localparam int NIN = 5;
  localparam int DW  = 32;
  localparam int FW  = DW + 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic [NIN-1:0]    in_valid, in_ready, route_hit;
  logic [NIN*FW-1:0] in_flit;
  logic              out_valid, out_ready;
  logic [FW-1:0]     out_flit;

  wh_out_alloc uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_flit(in_flit), .route_hit(route_hit), .out_valid(out_valid),
    .out_ready(out_ready), .out_flit(out_flit)
  );

  int checks = 0;
  int fails  = 0;
  logic [FW-1:0] exp_q [NIN][$];
  int src_q[$];
  int cur_src = -1;
  logic rand_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  assign out_ready = rand_en ? lfsr[0] : 1'b1;
  always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

  task automatic check(input bit ok, input string rq, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic send(input int i, input logic [1:0] k, input logic [DW-1:0] d, input bit track);
    @(negedge clk);
    in_valid[i] = 1'b1;
    in_flit[i*FW +: FW] = {k, d};
    while (!in_ready[i]) @(negedge clk);
    if (track) exp_q[i].push_back({k, d});
    @(negedge clk);
    in_valid[i] = 1'b0;
  endtask

  function automatic bit all_done();
    if (src_q.size() != 0 || cur_src != -1) return 1'b0;
    for (int i = 0; i < NIN; i++) if (exp_q[i].size() != 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic drain();
    int n = 0;
    while (!all_done() && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(n < 3000, "R6 drain", FW'(n), FW'(3000));
  endtask

  // Scoreboard monitor: samples mid-low-phase, i.e. the transfer at the next edge.
  logic prev_stall = 1'b0;
  logic [FW-1:0] prev_flit = '0;
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rst_n) begin
        if (prev_stall) check(out_valid && out_flit == prev_flit, "R7 stall hold", out_flit, prev_flit);
        prev_stall = out_valid && !out_ready;
        prev_flit  = out_flit;
        if (out_valid && out_ready) begin
          if (out_flit[FW-2]) begin
            check(cur_src == -1, "R4 head inside open packet", out_flit, '0);
            if (src_q.size() == 0) begin
              check(1'b0, "R5 unexpected packet", out_flit, '0);
              cur_src = -1;
            end else cur_src = src_q.pop_front();
          end
          if (cur_src < 0 || exp_q[cur_src].size() == 0) begin
            check(1'b0, "R8 unexpected flit", out_flit, '0);
          end else begin
            logic [FW-1:0] e;
            e = exp_q[cur_src].pop_front();
            check(out_flit == e, "R4 R5 R8 flit order", out_flit, e);
          end
          if (out_flit[FW-1]) cur_src = -1;
        end
      end
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R6 watchdog actual=hung expected=finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = '0;
    in_flit = '0;
    route_hit = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", FW'(out_valid), '0);
    check(in_ready == '1, "R1 in_ready", FW'(in_ready), FW'(5'h1f));

    // Phase A: all inputs loaded, routes held off, then released together.
    send(0, 2'b01, 32'hA000_0000, 1); send(0, 2'b00, 32'hA000_0001, 1); send(0, 2'b10, 32'hA000_0002, 1);
    send(1, 2'b11, 32'hA100_0000, 1);
    send(2, 2'b01, 32'hA200_0000, 1); send(2, 2'b10, 32'hA200_0001, 1);
    send(3, 2'b01, 32'hA300_0000, 1); send(3, 2'b00, 32'hA300_0001, 1);
    send(3, 2'b00, 32'hA300_0002, 1); send(3, 2'b10, 32'hA300_0003, 1);
    send(4, 2'b01, 32'hA400_0000, 1); send(4, 2'b00, 32'hA400_0001, 1); send(4, 2'b10, 32'hA400_0002, 1);
    check(in_ready[3] == 1'b0, "R2 full fifo not ready", FW'(in_ready[3]), '0);
    check(in_ready[1] == 1'b1, "R2 partial fifo ready", FW'(in_ready[1]), FW'(1));
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R3 no route no grant", FW'(out_valid), '0);
    end
    src_q = {0, 1, 2, 3, 4};
    route_hit = '1;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 stage one", FW'(out_valid), '0);
    @(negedge clk);
    check(out_valid && out_flit == {2'b01, 32'hA000_0000}, "R5 R9 entry head out", out_flit, {2'b01, 32'hA000_0000});
    drain();

    // Phase B: network inputs only, random back-pressure.
    route_hit = '0;
    send(1, 2'b01, 32'hB100_0000, 1); send(1, 2'b10, 32'hB100_0001, 1);
    send(2, 2'b11, 32'hB200_0000, 1);
    send(3, 2'b01, 32'hB300_0000, 1); send(3, 2'b00, 32'hB300_0001, 1); send(3, 2'b10, 32'hB300_0002, 1);
    send(4, 2'b01, 32'hB400_0000, 1); send(4, 2'b10, 32'hB400_0001, 1);
    src_q = {1, 2, 3, 4};
    @(negedge clk);
    rand_en = 1'b1;
    route_hit = '1;
    drain();
    @(negedge clk);
    rand_en = 1'b0;

    // Phase C: entry port asks while input 1 holds the channel mid-packet.
    src_q = {1, 0};
    send(1, 2'b01, 32'hC100_0000, 1);
    repeat (4) @(negedge clk);
    send(0, 2'b11, 32'hC000_0000, 1);
    repeat (4) @(negedge clk);
    send(1, 2'b00, 32'hC100_0001, 1);
    send(1, 2'b10, 32'hC100_0002, 1);
    drain();

    // Phase D: a stray body flit at a FIFO front never takes the channel.
    send(2, 2'b00, 32'hD200_0000, 0);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R3 body flit no grant", FW'(out_valid), '0);
    end

    summary();
    $finish;
  end
endmodule